// File: doc/BRIEF.md
# Reference Tick Divider with Regional Rate Selection

This block turns a crystal clock into the reference ticks that feed two phase detectors, one for the transmit loop and one for the receive loop. A programmable base divider produces tick A once every N crystal cycles, where N is a 12-bit ratio. Two fixed post-dividers then count A ticks: one produces tick B on every fourth A and the other produces tick C on every twenty-fifth A. A 2-bit region code picks which of these ticks each phase detector receives. The two loops can therefore run at different reference rates when a regional channel plan requires it.

The ratio and the region code are captured together on a single-cycle load strobe. The same strobe restarts every counter, so the tick pattern always starts from a known phase after each load. Two intermediate taps, named first and second stage, are brought out so that a test mode can observe them on a shared status pin. Every output is a registered single-cycle pulse in the crystal clock domain.

Top module: `ref_tick_divider`

## Requirements
- R1: While reset is high, and in the first cycle after it, all seven tick outputs are low. Reset installs the ratio 2048 and region code 2'b00, whatever the `ratio_in` and `region_in` ports carry.
- R2: After reset is released, with no load, tick A first pulses 2048 cycles after the last clock edge that samples reset high, and then every 2048 cycles.
- R3: After the clock edge that samples `load` high with a ratio N in 16..4095, `tick_a` pulses exactly at cycles N, 2N, 3N and so on, counted from that edge.
- R4: A loaded ratio below 16 behaves as the ratio 16.
- R5: `tick_b` pulses in the same cycle as every fourth `tick_a`, and `tick_c` in the same cycle as every twenty-fifth `tick_a`, both counted from the last load or reset.
- R6: Every tick output is high for exactly one cycle at a time.
- R7: The region code selects the transmit and receive ticks as follows: 2'b00 gives A to both; 2'b01 gives B to both; 2'b10 gives B to transmit and C to receive; 2'b11 gives C to transmit and B to receive.
- R8: The first-stage tap carries A for codes 2'b00 and 2'b01 and carries B for 2'b10 and 2'b11. The second-stage tap stays low for 2'b00, carries B for 2'b01, and carries C for 2'b10 and 2'b11.
- R9: A load restarts the base divider and both post-dividers, so the pattern from R3 and R5 starts over. In the load cycle all outputs are low. Changes on `ratio_in` or `region_in` without a load have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures ratio and region code and restarts all counters |
| ratio_in | input | 12 | Base division ratio |
| region_in | input | 2 | Region code for tick routing |
| tick_a | output | 1 | Base reference tick |
| tick_b | output | 1 | Base tick divided by 4 |
| tick_c | output | 1 | Base tick divided by 25 |
| ref_tx | output | 1 | Reference tick for the transmit phase detector |
| ref_rx | output | 1 | Reference tick for the receive phase detector |
| tap_fr1 | output | 1 | First-stage observation tap |
| tap_fr2 | output | 1 | Second-stage observation tap |

## Verification
The assertions assume that `load` and `rst` are the only events that restart counting. They also assume that any ratio below the legal floor is clamped before it reaches the counter, so that a base tick can never follow another in the next cycle. The stimulus holds `load` high for one cycle at a time and keeps it low during reset. It includes a ratio below the floor only to exercise the clamp. After each load it deliberately changes the ratio and region inputs, which shows that they are ignored until the next strobe.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  typedef enum logic [1:0] {
    RG_ALL_A   = 2'b00,
    RG_ALL_B   = 2'b01,
    RG_TXB_RXC = 2'b10,
    RG_TXC_RXB = 2'b11
  } region_e;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
  } tap_set_t;

  typedef struct packed {
    logic tx;
    logic rx;
    logic fr1;
    logic fr2;
  } route_t;

  function automatic route_t route_pick(input region_e rg, input tap_set_t t);
    route_t r;
    case (rg)
      RG_ALL_A:   r = '{tx: t.a, rx: t.a, fr1: t.a, fr2: 1'b0};
      RG_ALL_B:   r = '{tx: t.b, rx: t.b, fr1: t.a, fr2: t.b};
      RG_TXB_RXC: r = '{tx: t.b, rx: t.c, fr1: t.b, fr2: t.c};
      default:    r = '{tx: t.c, rx: t.b, fr1: t.b, fr2: t.c};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/refdiv_base.sv
module refdiv_base #(
  parameter int RATIO_W   = 12,
  parameter int MIN_RATIO = 16,
  parameter int DEF_RATIO = 2048
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               hit_o
);
  localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] DEFV  = RATIO_W'(DEF_RATIO);

  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] clamped;
  logic               at_end;

  assign clamped = (ratio_in < FLOOR) ? FLOOR : ratio_in;
  assign at_end  = (cnt == ratio_q - RATIO_W'(1));
  assign hit_o   = at_end && !load && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= DEFV;
      cnt     <= '0;
    end else if (load) begin
      ratio_q <= clamped;
      cnt     <= '0;
    end else if (at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + RATIO_W'(1);
    end
  end

  // R3: the running count stays below the active ratio
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < ratio_q);

  // R4: the active ratio never sits below the floor
  a_r4_ratio_floor: assert property (@(posedge clk) disable iff (rst)
    ratio_q >= FLOOR);

endmodule

// File: rtl/refdiv_post.sv
module refdiv_post #(
  parameter int MOD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic hit_o
);
  localparam int CW = (MOD > 1) ? $clog2(MOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);

  logic [CW-1:0] cnt;

  assign hit_o = step && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end
  end

  // R5: the post count never passes its modulus
  a_r5_post_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/refdiv_route.sv
module refdiv_route
  import refdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clear,
  input  region_e  region,
  input  tap_set_t taps,
  output logic     tick_a,
  output logic     tick_b,
  output logic     tick_c,
  output logic     ref_tx,
  output logic     ref_rx,
  output logic     tap_fr1,
  output logic     tap_fr2
);
  route_t sel_r;

  assign sel_r = route_pick(region, taps);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      {tick_a, tick_b, tick_c}            <= '0;
      {ref_tx, ref_rx, tap_fr1, tap_fr2}  <= '0;
    end else begin
      tick_a  <= taps.a;
      tick_b  <= taps.b;
      tick_c  <= taps.c;
      ref_tx  <= sel_r.tx;
      ref_rx  <= sel_r.rx;
      tap_fr1 <= sel_r.fr1;
      tap_fr2 <= sel_r.fr2;
    end
  end

  // R7: a routed reference pulse always coincides with a base tick
  a_r7_tx_on_base: assert property (@(posedge clk) disable iff (rst)
    ref_tx |-> tick_a);
  a_r7_rx_on_base: assert property (@(posedge clk) disable iff (rst)
    ref_rx |-> tick_a);

  // R8: the second tap only pulses together with a divided tick
  a_r8_fr2_divided: assert property (@(posedge clk) disable iff (rst)
    tap_fr2 |-> (tick_b || tick_c));

endmodule

// File: rtl/ref_tick_divider.sv
module ref_tick_divider
  import refdiv_pkg::*;
#(
  parameter int RATIO_W   = 12,
  parameter int MIN_RATIO = 16,
  parameter int DEF_RATIO = 2048,
  parameter int DIV_B     = 4,
  parameter int DIV_C     = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic [1:0]         region_in,
  output logic               tick_a,
  output logic               tick_b,
  output logic               tick_c,
  output logic               ref_tx,
  output logic               ref_rx,
  output logic               tap_fr1,
  output logic               tap_fr2
);
  region_e  region_q;
  tap_set_t taps;

  always_ff @(posedge clk) begin
    if (rst)       region_q <= RG_ALL_A;
    else if (load) region_q <= region_e'(region_in);
  end

  refdiv_base #(
    .RATIO_W  (RATIO_W),
    .MIN_RATIO(MIN_RATIO),
    .DEF_RATIO(DEF_RATIO)
  ) u_base (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .ratio_in(ratio_in),
    .hit_o   (taps.a)
  );

  refdiv_post #(.MOD(DIV_B)) u_div_b (
    .clk  (clk),
    .rst  (rst),
    .clear(load),
    .step (taps.a),
    .hit_o(taps.b)
  );

  refdiv_post #(.MOD(DIV_C)) u_div_c (
    .clk  (clk),
    .rst  (rst),
    .clear(load),
    .step (taps.a),
    .hit_o(taps.c)
  );

  refdiv_route u_route (
    .clk    (clk),
    .rst    (rst),
    .clear  (load),
    .region (region_q),
    .taps   (taps),
    .tick_a (tick_a),
    .tick_b (tick_b),
    .tick_c (tick_c),
    .ref_tx (ref_tx),
    .ref_rx (ref_rx),
    .tap_fr1(tap_fr1),
    .tap_fr2(tap_fr2)
  );

  // R1: outputs are quiet in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(tick_a || tick_b || tick_c || ref_tx || ref_rx || tap_fr1 || tap_fr2));

  // R5: divided ticks land on a base tick
  a_r5_b_with_a: assert property (@(posedge clk) disable iff (rst)
    tick_b |-> tick_a);
  a_r5_c_with_a: assert property (@(posedge clk) disable iff (rst)
    tick_c |-> tick_a);

  // R6: the base tick never lasts two cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tick_a |=> !tick_a);

  // R9: the cycle after a load edge carries no pulse
  a_r9_load_clears: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> !(tick_a || ref_tx || ref_rx));

endmodule

// File: tb/sim_ref_tick_divider.sv
`timescale 1ns/1ps
module sim_ref_tick_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [11:0] ratio_in = 12'd100;
  logic [1:0]  region_in = 2'b11;
  logic tick_a, tick_b, tick_c, ref_tx, ref_rx, tap_fr1, tap_fr2;

  always #4 clk = ~clk;

  ref_tick_divider u0 (
    .clk(clk), .rst(rst), .load(load), .ratio_in(ratio_in), .region_in(region_in),
    .tick_a(tick_a), .tick_b(tick_b), .tick_c(tick_c), .ref_tx(ref_tx),
    .ref_rx(ref_rx), .tap_fr1(tap_fr1), .tap_fr2(tap_fr2)
  );

  typedef struct {
    int    eff;
    int    sel;
    int    len;
    string tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit mon_busy = 0;
  bit done = 0;
  string nm[7] = '{"tick_a", "tick_b", "tick_c", "ref_tx", "ref_rx", "tap_fr1", "tap_fr2"};

  function automatic logic [6:0] observed();
    return {tick_a, tick_b, tick_c, ref_tx, ref_rx, tap_fr1, tap_fr2};
  endfunction

  // expected outputs k cycles after the restart edge (R3, R5, R7, R8)
  function automatic logic [6:0] expect_at(int k, int eff, int sel);
    logic a, b, c, tx, rx, f1, f2;
    a = (k > 0) && (k % eff == 0);
    b = a && ((k / eff) % 4 == 0);
    c = a && ((k / eff) % 25 == 0);
    case (sel)
      0:       begin tx = a; rx = a; f1 = a; f2 = 1'b0; end
      1:       begin tx = b; rx = b; f1 = a; f2 = b;    end
      2:       begin tx = b; rx = c; f1 = b; f2 = c;    end
      default: begin tx = c; rx = b; f1 = b; f2 = c;    end
    endcase
    return {a, b, c, tx, rx, f1, f2};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: one restart per item, then scrambles inputs without a load (R9)
  task automatic run_load(int ratio, int eff, int sel, int len, string tag);
    item_t it;
    it.eff = eff; it.sel = sel; it.len = len; it.tag = tag;
    q.push_back(it);
    ratio_in  = 12'(ratio);
    region_in = 2'(sel);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    ratio_in  = 12'(ratio ^ 12'h5a3);
    region_in = ~2'(sel);
    repeat (len) @(negedge clk);
  endtask

  // monitor: pops items and compares every cycle of each window
  initial begin
    forever begin
      item_t it;
      logic [6:0] first_act [7];
      logic [6:0] first_exp [7];
      int first_k [7];
      bit miss [7];
      wait (q.size() > 0);
      mon_busy = 1;
      it = q.pop_front();
      for (int j = 0; j < 7; j++) begin miss[j] = 0; first_k[j] = 0; end
      @(negedge clk);
      check(observed() == 7'd0, "R9", {it.tag, " outputs in restart cycle"}, int'(observed()), 0);
      for (int k = 1; k <= it.len; k++) begin
        logic [6:0] o, e;
        @(negedge clk);
        o = observed();
        e = expect_at(k, it.eff, it.sel);
        for (int j = 0; j < 7; j++) begin
          if (o[6-j] !== e[6-j] && !miss[j]) begin
            miss[j] = 1; first_k[j] = k; first_act[j] = o; first_exp[j] = e;
          end
        end
      end
      for (int j = 0; j < 7; j++) begin
        string req;
        req = (j < 3) ? "R3/R5" : ((j < 5) ? "R7" : "R8");
        total++;
        if (miss[j]) begin
          bad++;
          $display("FAIL %s %s %s at cycle %0d actual=%0b expected=%0b", req, it.tag, nm[j],
                   first_k[j], first_act[j][6-j], first_exp[j][6-j]);
        end
      end
      mon_busy = 0;
    end
  end

  // R6: no tick output stays high two cycles in a row
  initial begin
    logic [6:0] prev = '0;
    forever begin
      @(negedge clk);
      if (!rst && ((prev & observed()) != 0)) begin
        total++; bad++;
        $display("FAIL R6 pulse wider than one cycle actual=%0b expected=0", prev & observed());
      end
      prev = observed();
    end
  end

  initial begin
    #(8ns * 200000);
    bad++; total++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    item_t it;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check(observed() == 7'd0, "R1", "outputs during reset", int'(observed()), 0);
    // R1, R2: reset installs ratio 2048 and code 00, ignoring ratio_in=100/region_in=3
    it.eff = 2048; it.sel = 0; it.len = 4200; it.tag = "R2 default after reset";
    q.push_back(it);
    @(negedge clk);
    rst = 1'b0;
    repeat (4200) @(negedge clk);
    run_load(16, 16, 0, 820, "R7 code00");
    run_load(16, 16, 1, 820, "R7 code01");
    run_load(16, 16, 2, 820, "R7 code10");
    run_load(16, 16, 3, 100, "R9 short window");
    run_load(16, 16, 3, 820, "R9 restart code11");
    run_load(5, 16, 3, 820, "R4 clamp of 5");
    run_load(17, 17, 2, 900, "R3 ratio17");
    run_load(4095, 4095, 1, 8300, "R3 ratio4095");
    wait (q.size() == 0 && !mon_busy);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule